// File: doc/BRIEF.md
# Fuse-Programmable AND-OR Array

This block is a sum-of-products logic core whose function is set by a fuse map held in on-chip flops. Sixteen array signals (ten dedicated inputs and six pin-return lines) each feed the array in both true and inverted form, giving 32 literal columns. There are 64 product terms, and every intact fuse ties one literal column into one product term. The terms fall into eight output slices of eight terms each. In every slice the first term is the slice's output-enable, and the other seven are ORed and inverted to form an active-low pin value.

The fuse map is written serially, one bit per clock while a load enable is held high, starting with the highest fuse number. A small controller counts the bits. It raises a ready flag once all 2048 have arrived and keeps every output enable off until then. Slices 1 to 6 serve bidirectional pins. The pad ring returns the level seen on each of these pins on a separate input vector, and that vector is what the array reads. Slices 0 and 7 are output-only.

The controller has three states. EMPTY is the state after reset, with no map loaded. SHIFT means a load is in progress. READY means the map is complete. EMPTY moves to SHIFT when the load enable is seen. SHIFT moves to READY when the last bit is taken. READY moves back to SHIFT when the load enable is seen again, which starts a fresh load.

Top module: `pal_array`

## Requirements
- R1: After reset, `cfg_done` is 0 and every bit of `pin_oe` is 0.
- R2: With `cfg_en` high, one bit of `cfg_bit` is taken on each rising clock edge. The first bit taken becomes fuse 2047 and the 2048th becomes fuse 0. `cfg_done` is 0 while fewer than 2048 bits have been taken and is 1 after the edge that takes the 2048th bit.
- R3: While `cfg_en` is low, no bit is taken and `cfg_done` holds its value. A load broken by idle cycles gives the same map as one without breaks, whatever `cfg_bit` does while idle.
- R4: Fuse number row×32+col connects column col to product term row. Column 2k carries signal k true and column 2k+1 carries signal k inverted. Signals 0 to 9 are `ded_in[0..9]` and signals 10 to 15 are `io_in[0..5]`. A fuse bit of 1 means intact (connected).
- R5: A product term whose fuses are all intact evaluates to 0. A product term whose fuses are all blown evaluates to 1.
- R6: Slice s owns terms 8s to 8s+7. Once loaded, `pin_out[s]` is the inverse of the OR of terms 8s+1 to 8s+7.
- R7: `pin_oe[s]` equals term 8s while `cfg_done` is 1, and is 0 while `cfg_done` is 0.
- R8: The array reads the returned pin levels from `io_in` whatever the state of `pin_oe`.
- R9: Raising `cfg_en` while `cfg_done` is 1 clears `cfg_done` after that edge and starts a new full 2048-bit load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse loader |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Load enable; one fuse bit is taken per clock while high |
| cfg_bit | input | 1 | Serial fuse data, highest fuse number first |
| cfg_done | output | 1 | High once a full map has been taken |
| ded_in | input | 10 | Dedicated array inputs |
| io_in | input | 6 | Returned levels of the bidirectional pins of slices 1 to 6 |
| pin_out | output | 8 | Active-low value of each slice |
| pin_oe | output | 8 | Output enable of each slice |

## Verification
A fault in the loader shows at the ports as soon as the map is used. A bit lost or taken twice shifts the whole map by one position, so the sum-of-products result is wrong on many input vectors in the first sweep after `cfg_done` rises. A bad bit count moves the `cfg_done` rise away from the expected edge, and the edge-by-edge sampling catches that within one clock. A literal column or term group wired to the wrong place changes `pin_out` or `pin_oe` on the same input vector that exposes it. The exhaustive 65536-vector sweeps therefore expose such a fault within one sweep.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int unsigned DED_INPUTS  = 10;
    localparam int unsigned BIDIR_PINS  = 6;
    localparam int unsigned SLICES      = 8;
    localparam int unsigned TERMS_EACH  = 8;

    typedef enum logic [1:0] {
        LD_EMPTY = 2'd0,
        LD_SHIFT = 2'd1,
        LD_READY = 2'd2
    } ld_state_t;
endpackage

// File: rtl/pal_fuse_loader.sv
module pal_fuse_loader
    import pal_pkg::*;
#(
    parameter int unsigned FUSES = 2048,
    localparam int unsigned CW   = $clog2(FUSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    output logic [FUSES-1:0] fuse_q,
    output logic [CW-1:0]    bit_cnt,
    output logic             done
);
    ld_state_t state_q, state_d;
    logic      last_bit;

    assign last_bit = (bit_cnt == CW'(FUSES - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_EMPTY;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_EMPTY: if (cfg_en)             state_d = LD_SHIFT;
            LD_SHIFT: if (cfg_en && last_bit) state_d = LD_READY;
            LD_READY: if (cfg_en)             state_d = LD_SHIFT;
            default:                          state_d = LD_EMPTY;
        endcase
    end

    // bit counter: restarts whenever a load begins from EMPTY or READY
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (cfg_en) begin
            if (state_q == LD_SHIFT) bit_cnt <= bit_cnt + 1'b1;
            else                     bit_cnt <= CW'(1);
        end
    end

    // fuse storage: first bit in ends at the top fuse number
    always_ff @(posedge clk) begin
        if (!rst_n)      fuse_q <= '0;
        else if (cfg_en) fuse_q <= {fuse_q[FUSES-2:0], cfg_bit};
    end

    // outputs from state
    always_comb begin
        done = (state_q == LD_READY);
    end
endmodule

// File: rtl/pal_term_plane.sv
module pal_term_plane #(
    parameter int unsigned SIGS  = 16,
    parameter int unsigned ROWS  = 64,
    localparam int unsigned COLS  = 2 * SIGS,
    localparam int unsigned FUSES = ROWS * COLS
) (
    input  logic [SIGS-1:0]  sig,
    input  logic [FUSES-1:0] fuse_q,
    output logic [ROWS-1:0]  term
);
    logic [COLS-1:0] lit;

    for (genvar k = 0; k < SIGS; k++) begin : g_lit
        assign lit[2*k]     = sig[k];
        assign lit[2*k + 1] = ~sig[k];
    end

    // a blown fuse forces its column to 1; intact ones pass the literal
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign term[r] = &(~fuse_q[r*COLS +: COLS] | lit);
    end
endmodule

// File: rtl/pal_slice_merge.sv
module pal_slice_merge #(
    parameter int unsigned SLICES     = 8,
    parameter int unsigned TERMS_EACH = 8,
    localparam int unsigned ROWS      = SLICES * TERMS_EACH
) (
    input  logic [ROWS-1:0]   term,
    input  logic              live,
    output logic [SLICES-1:0] pin_out,
    output logic [SLICES-1:0] pin_oe
);
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        assign pin_oe[s]  = live & term[s*TERMS_EACH];
        assign pin_out[s] = ~(|term[s*TERMS_EACH + 1 +: TERMS_EACH - 1]);
    end
endmodule

// File: rtl/pal_array.sv
module pal_array
    import pal_pkg::*;
#(
    parameter int unsigned N_DED  = DED_INPUTS,
    parameter int unsigned N_IO   = BIDIR_PINS,
    parameter int unsigned N_SL   = SLICES,
    parameter int unsigned N_TERM = TERMS_EACH,
    localparam int unsigned N_SIG = N_DED + N_IO,
    localparam int unsigned N_ROW = N_SL * N_TERM,
    localparam int unsigned FUSES = N_ROW * 2 * N_SIG,
    localparam int unsigned CW    = $clog2(FUSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    output logic             cfg_done,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_IO-1:0]  io_in,
    output logic [N_SL-1:0]  pin_out,
    output logic [N_SL-1:0]  pin_oe
);
    logic [FUSES-1:0] fuse_q;
    logic [CW-1:0]    ld_cnt;
    logic [N_ROW-1:0] term;
    logic [N_SIG-1:0] sig;

    assign sig = {io_in, ded_in};

    pal_fuse_loader #(.FUSES(FUSES)) loader_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .fuse_q  (fuse_q),
        .bit_cnt (ld_cnt),
        .done    (cfg_done)
    );

    pal_term_plane #(.SIGS(N_SIG), .ROWS(N_ROW)) plane_i (
        .sig    (sig),
        .fuse_q (fuse_q),
        .term   (term)
    );

    pal_slice_merge #(.SLICES(N_SL), .TERMS_EACH(N_TERM)) merge_i (
        .term    (term),
        .live    (cfg_done),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
    parameter int unsigned N_SL  = 8,
    parameter int unsigned FUSES = 2048,
    localparam int unsigned CW   = $clog2(FUSES + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_en,
    input logic            cfg_done,
    input logic [N_SL-1:0] pin_oe,
    input logic [CW-1:0]   ld_cnt
);
    // R7: drivers stay off until a full map is present
    p_oe_off_unloaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (pin_oe == '0));

    // R2: ready can only appear on an edge that took a bit
    p_done_needs_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(cfg_en));

    // R2: bit count never exceeds the map size
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cnt <= CW'(FUSES));

    // R3: an idle cycle changes neither progress nor ready
    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> ($stable(ld_cnt) && $stable(cfg_done)));

    // R9: a new load drops ready at once
    p_reload_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && cfg_en) |=> !cfg_done);
endmodule

bind pal_array pal_array_chk #(.N_SL(N_SL), .FUSES(FUSES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_done (cfg_done),
    .pin_oe   (pin_oe),
    .ld_cnt   (ld_cnt)
);

// File: tb/pal_array_tb.sv
module pal_array_tb_top;
    localparam int NF = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_bit = 1'b0;
    logic       cfg_done;
    logic [9:0] ded_in = '0;
    logic [5:0] io_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pal_array dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .cfg_done(cfg_done), .ded_in(ded_in), .io_in(io_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference: per requirement R4/R5/R6, returns {oe, out}
    function automatic logic [15:0] ref_eval(input logic [NF-1:0] m, input logic [9:0] d, input logic [5:0] io);
        logic [15:0] sg;
        logic [63:0] t;
        logic [7:0]  oe, o;
        sg = {io, d};
        for (int r = 0; r < 64; r++) begin
            t[r] = 1'b1;
            for (int k = 0; k < 16; k++) begin
                if (m[r*32 + 2*k] && !sg[k])    t[r] = 1'b0;
                if (m[r*32 + 2*k + 1] && sg[k]) t[r] = 1'b0;
            end
        end
        for (int s = 0; s < 8; s++) begin
            oe[s] = t[8*s];
            o[s]  = 1'b0;
            for (int j = 1; j < 8; j++) o[s] = o[s] | t[8*s + j];
            o[s] = ~o[s];
        end
        return {oe, o};
    endfunction

    task automatic load_map(input logic [NF-1:0] m, input bit gaps);
        for (int i = NF - 1; i >= 0; i--) begin
            if (gaps) begin
                while ($urandom_range(0, 3) == 0) begin
                    @(negedge clk);
                    cfg_en  = 1'b0;
                    cfg_bit = 1'($urandom);
                end
            end
            @(negedge clk);
            if (i == NF - 2) check(cfg_done == 1'b0, "R9 done low after first bit", 32'(cfg_done), 0);
            if (i == 1024)   check(pin_oe == 8'h00, "R7 oe off mid-load", 32'(pin_oe), 0);
            if (i == 0)      check(cfg_done == 1'b0, "R2 done low before last bit", 32'(cfg_done), 0);
            cfg_en  = 1'b1;
            cfg_bit = m[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        check(cfg_done == 1'b1, "R2 done after last bit", 32'(cfg_done), 1);
        repeat (3) begin
            cfg_bit = ~cfg_bit;
            @(negedge clk);
        end
        check(cfg_done == 1'b1, "R3 done holds while idle", 32'(cfg_done), 1);
    endtask

    task automatic sweep(input logic [NF-1:0] m, input bit full, input int n, input string req);
        logic [15:0] v, e;
        @(negedge clk);
        #1;
        for (int i = 0; i < (full ? 65536 : n); i++) begin
            v = full ? 16'(i) : 16'($urandom);
            {io_in, ded_in} = v;
            #2;
            e = ref_eval(m, ded_in, io_in);
            check({pin_oe, pin_out} == e, req, 32'({pin_oe, pin_out}), 32'(e));
        end
    endtask

    function automatic logic [NF-1:0] sparse_map();
        logic [NF-1:0] m;
        for (int i = 0; i < NF; i++) m[i] = ($urandom_range(0, 15) == 0);
        return m;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NF-1:0] m;
        repeat (3) @(negedge clk);
        check(cfg_done == 1'b0, "R1 done after reset", 32'(cfg_done), 0);
        check(pin_oe == 8'h00, "R1 oe after reset", 32'(pin_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cfg_done == 1'b0, "R1 done idle", 32'(cfg_done), 0);

        // R5: all intact -> all terms 0: out all 1, oe all 0
        m = '1;
        load_map(m, 0);
        sweep(m, 0, 200, "R5 all intact");
        check(pin_out == 8'hFF && pin_oe == 8'h00, "R5 all-intact pins", 32'({pin_oe, pin_out}), 32'h00FF);

        // R5/R9: reload all blown -> all terms 1: out 0, oe 1
        m = '0;
        load_map(m, 0);
        check(pin_out == 8'h00 && pin_oe == 8'hFF, "R5 all-blown pins", 32'({pin_oe, pin_out}), 32'hFF00);

        // R4/R8: row 0 uses col 0 (ded_in[0] true); row 1 uses col 21 (io_in[0] inverted)
        m = '1;
        m[0 +: 32] = 32'h1;
        m[32 +: 32] = 32'h1 << 21;
        load_map(m, 0);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            ded_in = {9'd0, 1'(a)};
            io_in  = {5'd0, 1'(a >> 1)};
            #1;
            check(pin_oe[0] == ded_in[0], "R4 enable column mapping", 32'(pin_oe[0]), 32'(ded_in[0]));
            check(pin_out[0] == io_in[0], "R8 io feedback inverted column", 32'(pin_out[0]), 32'(io_in[0]));
            check(pin_oe[7:1] == 7'd0 && pin_out[7:1] == 7'h7F, "R6 other slices idle", 32'({pin_oe, pin_out}), 32'(8'hFE));
        end

        // R6/R4: sparse random maps, exhaustive sweep
        m = sparse_map();
        load_map(m, 0);
        sweep(m, 1, 0, "R6 exhaustive map A");

        // R3: load broken by idle cycles with noise on cfg_bit
        m = sparse_map();
        load_map(m, 1);
        sweep(m, 1, 0, "R3 gapped load exhaustive");

        for (int k = 0; k < 3; k++) begin
            m = sparse_map();
            load_map(m, k[0]);
            sweep(m, 0, 2000, "R6 random map random vectors");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule